// File: doc/BRIEF.md
# Quad Flash Execute-in-Place Read Front-End

This block lets a simple bus master read an external serial flash as plain memory. A word read whose address falls inside the flash window starts a four-line fast-read sequence to the flash. The block sends the opcode, the 24-bit address, a mode byte and a few dummy clocks, and then shifts in data. The requested word goes back on the same handshake. After the first word, chip select stays low and the flash keeps streaming, so the following bytes collect in a small prefetch buffer. A later read of the next word is then answered from that buffer without any new command.

The mode byte places the flash in continuous-read mode. Every sequence after the first therefore starts directly with the address and leaves out the opcode. A held read ends in three cases: a read to any other address, an optional idle timeout, or an explicit exit request. The exit request sends a short read whose mode byte is the complement of the entry value. This returns the flash to normal command mode, and the next sequence carries the opcode again.

The request interface uses valid/ready. The master holds `req_valid` and `req_addr` stable until `req_ready` is high. The word is taken on the clock edge where both are high, with `rdata` and `rsp_err` valid in that same cycle. The block applies back-pressure by keeping `req_ready` low until four bytes for the requested address are buffered.

Top module: `qflash_xip_rd`

## Requirements
- R1: A read with `req_addr[31:AW]` not equal to `BASE[31:AW]` is answered in the same cycle with `req_ready`=1, `rsp_err`=1 and `rdata`=0. It starts no flash sequence and does not disturb a held read.
- R2: The first sequence after reset, and the first after an exit, drives all on `fl_io_o[3:0]`, high nibble first: opcode 0xEB (2 nibbles), then the 24-bit byte address (6 nibbles, most significant first), then mode byte 0xA0. `fl_io_oe` then drops for DUMMY clocks, after which each data byte is sampled high nibble first.
- R3: Every later read sequence leaves out the opcode and starts with the address nibbles.
- R4: `rdata` holds the four flash bytes at offsets A..A+3, with byte A in bits 7:0. `req_ready` stays low for an in-window read until those bytes are buffered.
- R5: While a read is held, a request for the word right after the last one returned is served from the prefetch buffer, and `fl_cs_n` stays low.
- R6: A non-sequential in-window read raises `fl_cs_n` for at least two cycles, discards the buffer and starts a new sequence at the requested address.
- R7: When the prefetch buffer is full, `fl_sclk` stays low with `fl_cs_n` low, and no flash clock edge occurs until a word is taken.
- R8: With `tmo_en`=1, a held read with no pending request for `tmo_period` cycles is closed and `fl_cs_n` goes high. With `tmo_en`=0, the read stays held indefinitely.
- R9: `busy` is 0 after reset and in idle, and it is 1 whenever `fl_cs_n` is low.
- R10: A pulse on `exit_req` while the flash is in continuous mode closes any held read. It then sends a sequence without opcode, carrying mode byte 0x5F and exactly one data byte (two clocks), and releases chip select.
- R11: `fl_sclk` is low whenever `fl_cs_n` is high, and each high phase of `fl_sclk` lasts exactly one system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Word read request valid |
| req_addr | input | 32 | Byte address of the requested word (word aligned) |
| req_ready | output | 1 | Request accepted; rdata and rsp_err valid this cycle |
| rdata | output | 32 | Read word, lowest address in bits 7:0 |
| rsp_err | output | 1 | Request fell outside the flash window |
| tmo_en | input | 1 | Enable the idle timeout on a held read |
| tmo_period | input | 16 | Idle cycles before a held read is closed |
| exit_req | input | 1 | Pulse: leave continuous-read mode |
| busy | output | 1 | A flash sequence is active or closing |
| fl_sclk | output | 1 | Flash serial clock |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_io_o | output | 4 | Flash data lines, outbound |
| fl_io_oe | output | 1 | Output enable for fl_io_o |
| fl_io_i | input | 4 | Flash data lines, inbound |

## Verification
The bench uses a behavioural flash model that decodes each sequence, so a design that sends the opcode on every sequence, or drops it after an exit, makes the model misparse the address and return wrong words. Sequential reads are counted against chip-select rises, which exposes a design that re-issues commands instead of prefetching. A long idle period with the timeout off checks that the clock is frozen while the buffer is full and that chip select stays low; a wrong design either keeps clocking and drops bytes or releases chip select. The exit sequence is checked for its complemented mode byte and its single data byte. An out-of-window access made while a read is held must neither stall nor close that read.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_GAP,
    S_SEND,
    S_DUMMY,
    S_DATA
  } qrd_state_e;

  localparam logic [7:0] OPC_QIO_READ = 8'hEB;
  localparam logic [7:0] MODE_HOLD    = 8'hA0;
  localparam int         HDR_NIB_OPC  = 10;
  localparam int         HDR_NIB_SKIP = 8;
endpackage

// File: rtl/qrd_pfb.sv
module qrd_pfb #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        push,
  input  logic [7:0]  push_byte,
  input  logic        pop,
  output logic [31:0] word,
  output logic        full,
  output logic        has_word
);
  localparam int PW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_p, rd_p;
  logic [PW:0]   fill;

  assign full     = (fill == (PW+1)'(DEPTH));
  assign has_word = (fill >= (PW+1)'(4));

  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic [PW-1:0] idx;
    assign idx = rd_p + PW'(i);
    assign word[8*i +: 8] = mem[idx];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_p] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      fill <= '0;
    end else if (flush) begin
      wr_p <= '0;
      rd_p <= '0;
      fill <= '0;
    end else begin
      if (push) wr_p <= wr_p + 1'b1;
      if (pop)  rd_p <= rd_p + PW'(4);
      fill <= fill + (PW+1)'(push) - (pop ? (PW+1)'(4) : '0);
    end
  end
endmodule

// File: rtl/qrd_idle_tmr.sv
module qrd_idle_tmr #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          run,
  input  logic [TW-1:0] period,
  output logic          expired
);
  logic [TW-1:0] cnt;

  assign expired = en && run && (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || !run)  cnt <= '0;
    else if (cnt != period) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/qflash_xip_rd.sv
module qflash_xip_rd
  import qrd_pkg::*;
#(
  parameter logic [31:0] BASE       = 32'h9000_0000,
  parameter int          AW         = 23,
  parameter int          FIFO_BYTES = 8,
  parameter int          DUMMY      = 4,
  parameter int          CS_GAP     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        req_ready,
  output logic [31:0] rdata,
  output logic        rsp_err,
  input  logic        tmo_en,
  input  logic [15:0] tmo_period,
  input  logic        exit_req,
  output logic        busy,
  output logic        fl_sclk,
  output logic        fl_cs_n,
  output logic [3:0]  fl_io_o,
  output logic        fl_io_oe,
  input  logic [3:0]  fl_io_i
);
  localparam int CNT_MAX0 = (DUMMY > CS_GAP) ? DUMMY : CS_GAP;
  localparam int CNT_MAX  = (CNT_MAX0 > HDR_NIB_OPC) ? CNT_MAX0 : HDR_NIB_OPC;
  localparam int CW       = $clog2(CNT_MAX + 1);

  qrd_state_e    st;
  logic          ph, byte_hi, instr_pend, exit_pend, exit_run;
  logic [CW-1:0] cnt;
  logic [39:0]   out_sh;
  logic [3:0]    hold;
  logic [AW-1:0] head_addr;

  logic          in_win, open_rd, hit, miss;
  logic          fb_full, fb_word, fb_push, fb_pop, tmo_hit;
  logic [31:0]   fb_data;
  logic          launch_exit, launch, start_now, close_now;
  logic [23:0]   launch_addr;
  logic [7:0]    launch_mode;

  assign in_win  = (req_addr[31:AW] == BASE[31:AW]);
  assign open_rd = (st == S_DATA) && !exit_run;
  assign hit     = open_rd && (req_addr[AW-1:0] == head_addr);
  assign miss    = req_valid && in_win && !hit;
  assign fb_pop  = req_valid && in_win && hit && fb_word;

  assign req_ready = req_valid && (!in_win || (hit && fb_word));
  assign rsp_err   = req_valid && !in_win;
  assign rdata     = in_win ? fb_data : 32'h0;
  assign busy      = (st != S_IDLE);
  assign fl_io_o   = out_sh[39:36];

  always_comb begin
    launch_exit = exit_pend && !instr_pend;
    launch      = launch_exit || miss;
    launch_addr = launch_exit ? 24'h0 : 24'(req_addr[AW-1:0]);
    launch_mode = launch_exit ? ~MODE_HOLD : MODE_HOLD;
    start_now   = launch && ((st == S_IDLE) || (st == S_GAP && cnt == CW'(1)));
    close_now   = (st == S_DATA) && !ph && byte_hi && !exit_run &&
                  (miss || tmo_hit || exit_pend);
  end

  assign fb_push = (st == S_DATA) && ph && !byte_hi && !exit_run;

  qrd_pfb #(.DEPTH(FIFO_BYTES)) u_pfb (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (start_now),
    .push      (fb_push),
    .push_byte ({hold, fl_io_i}),
    .pop       (fb_pop),
    .word      (fb_data),
    .full      (fb_full),
    .has_word  (fb_word)
  );

  qrd_idle_tmr #(.TW(16)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (tmo_en),
    .run     (open_rd && !req_valid),
    .period  (tmo_period),
    .expired (tmo_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ph <= 1'b0;  byte_hi <= 1'b1;  hold <= '0;
      cnt <= '0;  out_sh <= '0;  head_addr <= '0;
      instr_pend <= 1'b1;  exit_pend <= 1'b0;  exit_run <= 1'b0;
      fl_sclk <= 1'b0;  fl_cs_n <= 1'b1;  fl_io_oe <= 1'b0;
    end else begin
      if (exit_req) exit_pend <= 1'b1;
      else if (exit_pend && instr_pend && st == S_IDLE) exit_pend <= 1'b0;
      if (fb_pop) head_addr <= head_addr + AW'(4);

      if (start_now) begin
        fl_cs_n   <= 1'b0;
        fl_io_oe  <= 1'b1;
        st        <= S_SEND;
        ph        <= 1'b0;
        exit_run  <= launch_exit;
        if (launch_exit) exit_pend <= 1'b0;
        head_addr <= launch_addr[AW-1:0];
        if (instr_pend) begin
          out_sh <= {OPC_QIO_READ, launch_addr, launch_mode};
          cnt    <= CW'(HDR_NIB_OPC);
        end else begin
          out_sh <= {launch_addr, launch_mode, 8'h00};
          cnt    <= CW'(HDR_NIB_SKIP);
        end
        instr_pend <= 1'b0;
      end else begin
        unique case (st)
          S_IDLE: ;
          S_GAP: begin
            if (cnt > CW'(1)) cnt <= cnt - 1'b1;
            else st <= S_IDLE;
          end
          S_SEND, S_DUMMY: begin
            if (!ph) begin
              fl_sclk <= 1'b1;  ph <= 1'b1;
            end else begin
              fl_sclk <= 1'b0;  ph <= 1'b0;
              if (st == S_SEND) out_sh <= out_sh << 4;
              if (cnt != CW'(1)) cnt <= cnt - 1'b1;
              else if (st == S_SEND) begin
                st <= S_DUMMY;  cnt <= CW'(DUMMY);  fl_io_oe <= 1'b0;
              end else begin
                st <= S_DATA;  byte_hi <= 1'b1;
              end
            end
          end
          S_DATA: begin
            if (!ph) begin
              if (close_now) begin
                fl_cs_n <= 1'b1;  st <= S_GAP;  cnt <= CW'(CS_GAP);
              end else if (!(byte_hi && fb_full && !exit_run)) begin
                fl_sclk <= 1'b1;  ph <= 1'b1;
              end
            end else begin
              fl_sclk <= 1'b0;  ph <= 1'b0;
              if (byte_hi) begin
                hold <= fl_io_i;  byte_hi <= 1'b0;
              end else begin
                byte_hi <= 1'b1;
                if (exit_run) begin
                  fl_cs_n <= 1'b1;  st <= S_GAP;  cnt <= CW'(CS_GAP);
                  exit_run <= 1'b0;  instr_pend <= 1'b1;
                end
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/qrd_chk.sv
module qrd_chk #(
  parameter logic [31:0] BASE = 32'h9000_0000,
  parameter int          AW   = 23
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_ready,
  input logic [31:0] rdata,
  input logic        rsp_err,
  input logic        busy,
  input logic        fl_sclk,
  input logic        fl_cs_n,
  input logic        fl_io_oe
);
  AST_OUTSIDE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:AW] != BASE[31:AW]) |-> (req_ready && rsp_err && rdata == 32'h0)); // R1
  AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    fl_io_oe |-> !fl_cs_n); // R2
  AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_cs_n) |=> fl_cs_n); // R6
  AST_BUSY_WHEN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_cs_n |-> busy); // R9
  AST_SCLK_DESEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> !fl_sclk); // R11
  AST_SCLK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_sclk) |=> $fell(fl_sclk)); // R11
endmodule

bind qflash_xip_rd qrd_chk #(.BASE(BASE), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_ready(req_ready), .rdata(rdata), .rsp_err(rsp_err), .busy(busy),
  .fl_sclk(fl_sclk), .fl_cs_n(fl_cs_n), .fl_io_oe(fl_io_oe)
);

// File: tb/qflash_xip_rd_tb.sv
module qflash_xip_rd_tb;
  localparam logic [31:0] BASE = 32'h9000_0000;
  localparam int DUMMY = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, tmo_en = 1'b0, exit_req = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] tmo_period = 16'd30;
  logic req_ready, rsp_err, busy, fl_sclk, fl_cs_n, fl_io_oe;
  logic [31:0] rdata;
  logic [3:0] fl_io_o;
  logic [3:0] fl_io_i = 4'h0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  qflash_xip_rd #(.BASE(BASE), .DUMMY(DUMMY)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rdata(rdata), .rsp_err(rsp_err),
    .tmo_en(tmo_en), .tmo_period(tmo_period), .exit_req(exit_req),
    .busy(busy), .fl_sclk(fl_sclk), .fl_cs_n(fl_cs_n), .fl_io_o(fl_io_o),
    .fl_io_oe(fl_io_oe), .fl_io_i(fl_io_i)
  );

  function automatic logic [7:0] fmem(input logic [23:0] a);
    return 8'(a * 24'd13) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] fword(input logic [23:0] a);
    return {fmem(a + 24'd3), fmem(a + 24'd2), fmem(a + 24'd1), fmem(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural flash model
  bit          cont = 1'b0, live = 1'b0, seq_instr;
  int          rise, ncmd, seq_n = 0, last_rises;
  logic [39:0] rx;
  logic [7:0]  seq_cmd, seq_mode, last_mode;
  logic [23:0] seq_addr;
  bit          last_instr;

  always @(negedge fl_cs_n) begin
    live = 1'b1; rise = 0; rx = '0;
    seq_instr = !cont; ncmd = seq_instr ? 10 : 8;
  end

  always @(posedge fl_sclk) begin
    if (rise < ncmd) begin
      rx = {rx[35:0], fl_io_o};
      if (rise == ncmd - 1) begin
        seq_addr = rx[31:8]; seq_mode = rx[7:0];
        seq_cmd  = seq_instr ? rx[39:32] : 8'h00;
      end
    end else if (rise >= ncmd + DUMMY) begin
      int k;
      logic [7:0] b;
      k = rise - (ncmd + DUMMY);
      b = fmem(seq_addr + 24'(k / 2));
      fl_io_i = (k % 2 == 0) ? b[7:4] : b[3:0];
    end
    rise++;
  end

  always @(posedge fl_cs_n) begin
    if (live) begin
      live = 1'b0; seq_n++;
      last_mode = seq_mode; last_instr = seq_instr;
      last_rises = rise - (ncmd + DUMMY);
      if (rise >= ncmd) cont = (seq_mode == 8'hA0);
    end
  end

  // scoreboard
  logic [32:0] expq[$];
  string       tagq[$];

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (expq.size() == 0) chk(1'b0, "R4", "unexpected response", rdata, 32'h0);
      else begin
        logic [32:0] e;
        string t;
        e = expq.pop_front(); t = tagq.pop_front();
        chk(rsp_err == e[32], t, "error flag", 32'(rsp_err), 32'(e[32]));
        chk(rdata == e[31:0], t, "read word", rdata, e[31:0]);
      end
    end
  end

  task automatic rd(input logic [31:0] a, input string tag);
    bit outside;
    outside = (a[31:23] != BASE[31:23]);
    expq.push_back(outside ? {1'b1, 32'h0} : {1'b0, fword(a[23:0])});
    tagq.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  initial begin
    #(2_000_000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n0, r0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after reset", 32'(busy), 0);
    chk(fl_cs_n == 1'b1 && fl_sclk == 1'b0, "R11", "deselected clock low",
        {30'b0, fl_cs_n, fl_sclk}, 32'h2);

    rd(32'h1000_0000, "R1");
    chk(seq_n == 0 && fl_cs_n, "R1", "outside read touched flash", 32'(seq_n), 0);

    rd(BASE + 32'h100, "R4");
    chk(seq_instr && seq_cmd == 8'hEB, "R2", "opcode on first sequence", 32'(seq_cmd), 32'hEB);
    chk(seq_addr == 24'h100, "R2", "address nibbles", 32'(seq_addr), 32'h100);
    chk(seq_mode == 8'hA0, "R2", "mode byte", 32'(seq_mode), 32'hA0);
    @(negedge clk);
    chk(busy && !fl_cs_n, "R9", "busy while selected", 32'(busy), 1);

    rd(BASE + 32'h104, "R5");
    rd(BASE + 32'h108, "R5");
    chk(seq_n == 0, "R5", "chip select rose on sequential read", 32'(seq_n), 0);

    idle(300);
    chk(!fl_cs_n && busy, "R8", "held read released with timeout off", 32'(fl_cs_n), 0);
    r0 = rise;
    idle(40);
    chk(rise == r0 && !fl_sclk, "R7", "clock ran with buffer full", 32'(rise - r0), 0);
    chk(!fl_cs_n, "R7", "chip select during stall", 32'(fl_cs_n), 0);

    rd(BASE + 32'h2000, "R6");
    chk(seq_n == 1, "R6", "chip select rises on jump", 32'(seq_n), 1);
    chk(seq_addr == 24'h2000, "R6", "new sequence address", 32'(seq_addr), 32'h2000);
    chk(!seq_instr, "R3", "opcode left out", 32'(seq_instr), 0);

    tmo_en = 1'b1;
    rd(BASE + 32'h2004, "R5");
    idle(100);
    chk(fl_cs_n && !busy, "R8", "timeout closes held read", {30'b0, fl_cs_n, busy}, 32'h2);

    rd(BASE + 32'h7F_FFF0, "R3");
    chk(!seq_instr && seq_addr == 24'h7FFFF0, "R3", "skip opcode after timeout",
        32'(seq_addr), 32'h7FFFF0);

    n0 = seq_n;
    @(posedge clk); #1 exit_req = 1'b1;
    @(posedge clk); #1 exit_req = 1'b0;
    idle(2);
    wait_idle();
    chk(last_mode == 8'h5F, "R10", "exit mode byte", 32'(last_mode), 32'h5F);
    chk(!last_instr && last_rises == 2, "R10", "exit data clocks", 32'(last_rises), 2);
    chk(!busy && fl_cs_n, "R10", "released after exit", 32'(busy), 0);

    tmo_en = 1'b0;
    rd(BASE + 32'h40, "R10");
    chk(seq_instr && seq_cmd == 8'hEB, "R10", "opcode after exit", 32'(seq_cmd), 32'hEB);

    n0 = seq_n;
    rd(BASE + 32'h80_0000, "R1");
    chk(!fl_cs_n && seq_n == n0, "R1", "outside read closed held read", 32'(seq_n), 32'(n0));
    rd(BASE + 32'h44, "R5");
    chk(seq_n == n0, "R5", "sequential after error", 32'(seq_n), 32'(n0));

    idle(5);
    chk(expq.size() == 0, "R4", "responses outstanding", 32'(expq.size()), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule